// File: doc/BRIEF.md
# Digital Potentiometer Wiper Control

This block keeps the wiper code of a resistor ladder with 2^CODE_W taps and drives the ladder's switches from it. A serial front end decodes the bus traffic and hands the block one write strobe per data byte. Each strobe carries the new code and two flags taken from the instruction byte. The first flag forces the wiper to mid-scale. The second flag puts the ladder into shutdown. In shutdown the A terminal is disconnected and the wiper is tied to the B end.

The block drives a one-hot tap-select vector, an enable that opens the A terminal, and an enable that shorts the wiper to B. It also returns the stored code for read-back. All state and all outputs are registered, so the switch controls change only on a clock edge and together. The shutdown state is kept apart from the code, so a code written during shutdown is held and takes effect when shutdown ends.

Top module: `wiper_ctrl`

## Requirements
- R1: After reset the stored code is mid-scale (0x80 for the default width of 8), shutdown is off, and exactly tap bit 128 of `tap_sel` is set.
- R2: When shutdown is off, `tap_sel` has exactly one bit set, at the index equal to the stored code. Code 0x00 sets bit 0, which is the tap at the B end.
- R3: A strobe with `wr_mid`=0 stores `wr_code`. `code_rd` shows the new value after exactly one clock edge.
- R4: A strobe with `wr_mid`=1 stores mid-scale whatever `wr_code` is. The value stays there on later cycles that have no strobe.
- R5: A strobe with `wr_off`=1 sets `a_open`=1 and `wb_short`=1 and clears every bit of `tap_sel`. That strobe's code is still stored and can be read back on `code_rd`.
- R6: Strobes made during shutdown update `code_rd` while `tap_sel` stays all zero. The first strobe with `wr_off`=0 selects the tap of the code that strobe stores.
- R7: With `wr_en`=0 the values on `wr_code`, `wr_mid` and `wr_off` have no effect. `code_rd`, `tap_sel`, `a_open` and `wb_short` all hold.
- R8: The outputs change only on a clock edge. Before the edge that samples a strobe, the outputs keep their old values.
- R9: A strobe with both flags set stores mid-scale and enters shutdown in the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset (power-on preset) |
| wr_en | input | 1 | Write strobe from the serial front end |
| wr_code | input | CODE_W | Data byte carried by the strobe |
| wr_mid | input | 1 | Mid-scale reset flag |
| wr_off | input | 1 | Shutdown flag |
| tap_sel | output | 2^CODE_W | One-hot tap select; bit 0 is the B end |
| a_open | output | 1 | Open the A terminal |
| wb_short | output | 1 | Short the wiper to B |
| code_rd | output | CODE_W | Stored code for read-back |

## Verification
A wrong stored code shows up on `code_rd` one edge after the strobe that caused it. When shutdown is off, the same error also shows on the position of the single bit set in `tap_sel`. A wrong shutdown state shows at once as a mismatch between the terminal enables and the number of bits set in `tap_sel`.

A code that is lost during shutdown stays hidden on the tap outputs. It is found by reading `code_rd` during shutdown and by checking the tap selected on the first strobe after shutdown ends. The random sequences mix all flag combinations with idle cycles whose inputs carry junk, so that any state that moves without a strobe is also caught.

// File: rtl/wpot_pkg.sv
package wpot_pkg;

    typedef enum logic {
        WP_RUN = 1'b0,
        WP_OFF = 1'b1
    } wp_mode_e;

    function automatic int unsigned wp_mid(input int unsigned w);
        return 32'd1 << (w - 1);
    endfunction

endpackage

// File: rtl/wpot_next.sv
module wpot_next
    import wpot_pkg::*;
#(
    parameter int CODE_W = 8
) (
    input  logic [CODE_W-1:0] code_q,
    input  wp_mode_e          mode_q,
    input  logic              wr_en,
    input  logic [CODE_W-1:0] wr_code,
    input  logic              wr_mid,
    input  logic              wr_off,
    output logic [CODE_W-1:0] code_d,
    output wp_mode_e          mode_d
);
    localparam logic [CODE_W-1:0] MID = CODE_W'(wp_mid(CODE_W));

    always_comb begin
        code_d = code_q;
        mode_d = mode_q;
        if (wr_en) begin
            // mid-scale flag wins over the data byte
            code_d = wr_mid ? MID : wr_code;
            mode_d = wr_off ? WP_OFF : WP_RUN;
        end
    end
endmodule

// File: rtl/wpot_decode.sv
module wpot_decode
    import wpot_pkg::*;
#(
    parameter int CODE_W = 8
) (
    input  logic [CODE_W-1:0]      code,
    input  wp_mode_e               mode,
    output logic [(1<<CODE_W)-1:0] tap,
    output logic                   a_open,
    output logic                   wb_short
);
    localparam int TAPS = 1 << CODE_W;

    logic run;
    assign run      = (mode == WP_RUN);
    assign a_open   = ~run;
    assign wb_short = ~run;

    for (genvar i = 0; i < TAPS; i++) begin : g_tap
        assign tap[i] = run && (code == CODE_W'(i));
    end
endmodule

// File: rtl/wiper_ctrl.sv
module wiper_ctrl
    import wpot_pkg::*;
#(
    parameter int CODE_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [CODE_W-1:0]        wr_code,
    input  logic                     wr_mid,
    input  logic                     wr_off,
    output logic [(1<<CODE_W)-1:0]   tap_sel,
    output logic                     a_open,
    output logic                     wb_short,
    output logic [CODE_W-1:0]        code_rd
);
    localparam int                TAPS = 1 << CODE_W;
    localparam logic [CODE_W-1:0] MID  = CODE_W'(wp_mid(CODE_W));

    typedef struct packed {
        wp_mode_e          mode;
        logic [CODE_W-1:0] code;
        logic [TAPS-1:0]   tap;
        logic              a_open;
        logic              wb_short;
    } wp_state_t;

    wp_state_t st_d, st_q;

    logic [CODE_W-1:0] code_n;
    wp_mode_e          mode_n;
    logic [TAPS-1:0]   tap_n;
    logic              a_open_n, wb_short_n;

    wpot_next #(.CODE_W(CODE_W)) u_next (
        .code_q  (st_q.code),
        .mode_q  (st_q.mode),
        .wr_en   (wr_en),
        .wr_code (wr_code),
        .wr_mid  (wr_mid),
        .wr_off  (wr_off),
        .code_d  (code_n),
        .mode_d  (mode_n)
    );

    // decode from next state so the switch controls move with the register
    wpot_decode #(.CODE_W(CODE_W)) u_dec (
        .code     (code_n),
        .mode     (mode_n),
        .tap      (tap_n),
        .a_open   (a_open_n),
        .wb_short (wb_short_n)
    );

    always_comb begin
        st_d          = st_q;
        st_d.mode     = mode_n;
        st_d.code     = code_n;
        st_d.tap      = tap_n;
        st_d.a_open   = a_open_n;
        st_d.wb_short = wb_short_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.mode     <= WP_RUN;
            st_q.code     <= MID;
            st_q.tap      <= TAPS'(1) << MID;
            st_q.a_open   <= 1'b0;
            st_q.wb_short <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tap_sel  = st_q.tap;
    assign a_open   = st_q.a_open;
    assign wb_short = st_q.wb_short;
    assign code_rd  = st_q.code;
endmodule

// File: rtl/wpot_chk.sv
module wpot_chk #(
    parameter int CODE_W = 8
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   wr_en,
    input logic [CODE_W-1:0]      wr_code,
    input logic                   wr_mid,
    input logic                   wr_off,
    input logic [(1<<CODE_W)-1:0] tap_sel,
    input logic                   a_open,
    input logic                   wb_short,
    input logic [CODE_W-1:0]      code_rd
);
    localparam logic [CODE_W-1:0] MID = CODE_W'(1 << (CODE_W - 1));

    // R2
    tap_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wb_short |-> ($countones(tap_sel) == 1 && tap_sel[code_rd]));

    // R5
    off_taps_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_short |-> (tap_sel == '0 && a_open));

    // R3
    data_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_mid) |=> code_rd == $past(wr_code));

    // R4
    mid_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_mid) |=> code_rd == MID);

    // R9
    off_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> wb_short == $past(wr_off));

    // R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(code_rd) && $stable(tap_sel) && $stable(wb_short)));
endmodule

bind wiper_ctrl wpot_chk #(.CODE_W(CODE_W)) u_wpot_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_code  (wr_code),
    .wr_mid   (wr_mid),
    .wr_off   (wr_off),
    .tap_sel  (tap_sel),
    .a_open   (a_open),
    .wb_short (wb_short),
    .code_rd  (code_rd)
);

// File: tb/wiper_ctrl_test.sv
module wiper_ctrl_test;
    localparam int CODE_W = 8;
    localparam int TAPS   = 1 << CODE_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [CODE_W-1:0] wr_code = '0;
    logic              wr_mid = 1'b0;
    logic              wr_off = 1'b0;
    logic [TAPS-1:0]   tap_sel;
    logic              a_open, wb_short;
    logic [CODE_W-1:0] code_rd;

    int checks = 0;
    int fails  = 0;

    logic [CODE_W-1:0] m_code;
    logic              m_off;

    always #2.5 clk = ~clk;

    wiper_ctrl #(.CODE_W(CODE_W)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_code(wr_code),
        .wr_mid(wr_mid), .wr_off(wr_off), .tap_sel(tap_sel),
        .a_open(a_open), .wb_short(wb_short), .code_rd(code_rd)
    );

    function automatic logic [TAPS-1:0] exp_tap(input logic [CODE_W-1:0] c, input logic off);
        logic [TAPS-1:0] t = '0;
        if (!off) t[c] = 1'b1;
        return t;
    endfunction

    task automatic check_all(input string req);
        checks++;
        if (code_rd !== m_code) begin
            fails++;
            $display("FAIL %s code_rd actual=%h expected=%h", req, code_rd, m_code);
        end
        checks++;
        if (a_open !== m_off || wb_short !== m_off) begin
            fails++;
            $display("FAIL %s a_open/wb_short actual=%b/%b expected=%b", req, a_open, wb_short, m_off);
        end
        checks++;
        if (tap_sel !== exp_tap(m_code, m_off)) begin
            fails++;
            $display("FAIL %s tap_sel actual=%h expected=%h", req, tap_sel, exp_tap(m_code, m_off));
        end
    endtask

    task automatic strobe(input logic [CODE_W-1:0] c, input logic mid, input logic off, input string req);
        @(negedge clk);
        wr_en = 1'b1; wr_code = c; wr_mid = mid; wr_off = off;
        #1;
        check_all({req, " R8 before edge"});
        @(negedge clk);
        wr_en = 1'b0;
        m_code = mid ? CODE_W'(TAPS / 2) : c;
        m_off  = off;
        check_all(req);
    endtask

    task automatic idle(input string req);
        @(negedge clk);
        wr_en = 1'b0; wr_code = CODE_W'($urandom); wr_mid = 1'($urandom); wr_off = 1'($urandom);
        @(negedge clk);
        check_all(req);
    endtask

    initial begin
        #20000000;
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd2718));
        m_code = 8'h80; m_off = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1 reset");
        strobe(8'h00, 0, 0, "R2 code zero B end");
        strobe(8'hFF, 0, 0, "R2 code top");
        strobe(8'h3C, 0, 0, "R3 plain write");
        strobe(8'h11, 1, 0, "R4 mid wins");
        idle("R4 mid persists");
        idle("R7 idle junk");
        strobe(8'h5A, 0, 1, "R5 shutdown");
        strobe(8'hA7, 0, 1, "R6 write in shutdown");
        idle("R7 idle in shutdown");
        strobe(8'h09, 0, 0, "R6 leave shutdown");
        strobe(8'h42, 1, 1, "R9 both flags");
        strobe(8'h42, 0, 0, "R6 exit after both");
        for (int i = 0; i < 400; i++) begin
            if ($urandom_range(0, 3) == 0)
                idle("R7 random idle");
            else
                strobe(CODE_W'($urandom), ($urandom_range(0, 4) == 0), 1'($urandom), "R3 random strobe");
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule